// File: doc/BRIEF.md
# Two-Phase Watchdog Timer with Early Warning

This block is a register-mapped watchdog. It has three 32-bit registers that software writes and reads over a plain bus of address, write strobe, write data and read data. A tick generator divides the bus clock by a power of two, which software picks. Ticks then drive a counter through two stages. When the first stage runs out, the block sets an early-warning flag and raises its interrupt line. When the second stage runs out, the block emits a one-cycle reset request, together with a code that says what kind of reset is wanted.

Software arms the timer with an enable bit, and keeps it from firing by writing a kick word. Once the first stage has expired, the timer is latched and the enable bit no longer has any hold on it. Only a kick can move it back to the start.

The controller has four states:
- `ST_IDLE`: disabled, with all counting held at zero.
- `ST_PHASE1`: the first stage is counting.
- `ST_PHASE2`: the second stage is counting and the timer is latched.
- `ST_FIRED`: the reset request has been issued.

The transitions are:
- `ST_IDLE` to `ST_PHASE1` when enabled.
- `ST_PHASE1` to `ST_IDLE` when disabled.
- `ST_PHASE1` to `ST_PHASE2` on expiry of the first stage.
- `ST_PHASE2` to `ST_PHASE1` on a kick.
- `ST_PHASE2` to `ST_FIRED` on expiry of the second stage.
- `ST_FIRED` stays put until a hardware reset.

Top module: `wdg_timer`

Register map (byte offsets):
- **0x0, kick:** writing 1 to bit 31 restarts the count.
- **0x4, status:** bit 31 is the first-stage flag and bit 30 is the second-stage flag. Writing 1 to a bit clears that flag.
- **0x8, control:** the fields are listed in R2.

## Requirements
- R1: After a hardware reset:
  - control reads 0x00000001 (mode 1, all other fields zero);
  - status reads 0;
  - `irq` and `rst_req` are low.
- R2: The control register is laid out as follows:
  - enable in bit 31;
  - tick scale S in bits 30:29;
  - first-stage length A in bits 26:22;
  - second-stage length B in bits 19:15;
  - reset mode in bits 1:0.
  
  All other bits read as zero, so writing all ones reads back 0xE7CF8003.
- R3: One tick is 2^(E+S) clocks, where E is the parameter `BASE_EXP`. Suppose the enabling write is taken at clock edge C. The first stage then expires at edge C+1+2^(E+S)·(A+1). At that edge status bit 31 sets, and a value of 0 for A still gives one full tick.
- R4: The second stage expires (B+1) ticks after the first. At that edge `rst_req` goes high for exactly one cycle, status bit 30 sets, and `rst_mode` holds the mode field: 0 for a whole-chip reset, 1 for a CPU-only reset, 2 for a software reset.
- R5: While the enable bit is 0 during the first stage, counting is held at zero and no flag or request appears. Enabling again counts from the start of the first stage.
- R6: After the first stage has expired, clearing the enable bit neither stops the timer nor changes when the reset request comes.
- R7: A write to offset 0x0 with bit 31 set restarts counting from the start of the first stage, also during the second stage. A write with bit 31 clear has no effect.
- R8: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. A clear that falls on the edge where the same flag sets leaves the flag set.
- R9: A kick that falls on the first-stage expiry edge wins. No flag sets, and the first stage starts again from that edge.
- R10: After the reset request, the block stays in `ST_FIRED`. Kicks and enable writes cause no further request until a hardware reset.
- R11: `irq` follows the first-stage status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | Reset request pulse, one cycle |
| rst_mode | output | 2 | Kind of reset requested, valid with and after the pulse |

## Verification
Two actions can fall on the same edge as the first-stage expiry: a status clear, and a kick. The bench computes the exact expiry edge from R3 and issues each write so that it lands on that edge. For the clear, the flag must survive, which it checks by reading status afterwards. For the kick, no flag must appear, and the later interrupt and reset edges must both shift by one full first stage measured from the kick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PHASE1 = 2'd1,
        ST_PHASE2 = 2'd2,
        ST_FIRED  = 2'd3
    } wdg_state_e;

    localparam int DATA_W  = 32;
    localparam int PHASE_W = 5;
    localparam int SCALE_W = 2;
    localparam int MODE_W  = 2;

    // byte offsets
    localparam int OFS_KICK = 0;
    localparam int OFS_STAT = 4;
    localparam int OFS_CTRL = 8;

    // bit positions
    localparam int KICK_BIT    = 31;
    localparam int STAT_A_BIT  = 31;
    localparam int STAT_B_BIT  = 30;
    localparam int CTRL_EN_BIT = 31;
    localparam int CTRL_SC_LSB = 29;
    localparam int CTRL_A_LSB  = 22;
    localparam int CTRL_B_LSB  = 15;
    localparam int CTRL_MD_LSB = 0;

    localparam logic [MODE_W-1:0] MODE_AT_RESET = 2'd1;

    localparam logic [DATA_W-1:0] CTRL_MASK =
          (DATA_W'(1) << CTRL_EN_BIT)
        | (DATA_W'((1 << SCALE_W) - 1) << CTRL_SC_LSB)
        | (DATA_W'((1 << PHASE_W) - 1) << CTRL_A_LSB)
        | (DATA_W'((1 << PHASE_W) - 1) << CTRL_B_LSB)
        | (DATA_W'((1 << MODE_W) - 1) << CTRL_MD_LSB);

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                set_a,
    input  logic                set_b,
    output logic                cfg_en,
    output logic [SCALE_W-1:0]  cfg_scale,
    output logic [PHASE_W-1:0]  cfg_len_a,
    output logic [PHASE_W-1:0]  cfg_len_b,
    output logic [MODE_W-1:0]   cfg_mode,
    output logic                kick,
    output logic                flag_a,
    output logic                flag_b
);

    localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(OFS_KICK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    logic wr_kick, wr_stat, wr_ctrl;
    logic clr_a, clr_b;
    logic unused_wdata_bits;

    assign wr_kick = bus_we && (bus_addr == A_KICK);
    assign wr_stat = bus_we && (bus_addr == A_STAT);
    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);

    assign kick  = wr_kick && bus_wdata[KICK_BIT];
    assign clr_a = wr_stat && bus_wdata[STAT_A_BIT];
    assign clr_b = wr_stat && bus_wdata[STAT_B_BIT];

    assign unused_wdata_bits = ^(bus_wdata & ~CTRL_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en    <= 1'b0;
            cfg_scale <= '0;
            cfg_len_a <= '0;
            cfg_len_b <= '0;
            cfg_mode  <= MODE_AT_RESET;
        end else if (wr_ctrl) begin
            cfg_en    <= bus_wdata[CTRL_EN_BIT];
            cfg_scale <= bus_wdata[CTRL_SC_LSB +: SCALE_W];
            cfg_len_a <= bus_wdata[CTRL_A_LSB +: PHASE_W];
            cfg_len_b <= bus_wdata[CTRL_B_LSB +: PHASE_W];
            cfg_mode  <= bus_wdata[CTRL_MD_LSB +: MODE_W];
        end
    end

    // set has priority over a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else begin
            if (set_a)      flag_a <= 1'b1;
            else if (clr_a) flag_a <= 1'b0;
            if (set_b)      flag_b <= 1'b1;
            else if (clr_b) flag_b <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT) begin
            bus_rdata[STAT_A_BIT] = flag_a;
            bus_rdata[STAT_B_BIT] = flag_b;
        end else if (bus_addr == A_CTRL) begin
            bus_rdata[CTRL_EN_BIT]            = cfg_en;
            bus_rdata[CTRL_SC_LSB +: SCALE_W] = cfg_scale;
            bus_rdata[CTRL_A_LSB +: PHASE_W]  = cfg_len_a;
            bus_rdata[CTRL_B_LSB +: PHASE_W]  = cfg_len_b;
            bus_rdata[CTRL_MD_LSB +: MODE_W]  = cfg_mode;
        end
    end

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        set_a |=> flag_a); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && !set_a) |=> !flag_a); // R8

endmodule

// File: rtl/wdg_tick.sv
module wdg_tick
    import wdg_pkg::*;
#(
    parameter int BASE_EXP = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);

    localparam int CNT_W = BASE_EXP + (1 << SCALE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] term;

    assign span = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + 32'(scale));
    assign term = CNT_W'(span - (CNT_W+1)'(1));
    assign tick = run && (cnt == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || restart)  cnt <= '0;
        else if (tick)             cnt <= '0;
        else                       cnt <= cnt + CNT_W'(1);
    end

    AST_PRESCALER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R5

    generate
        if (BASE_EXP >= 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R3
        end
    endgenerate

endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm
    import wdg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [PHASE_W-1:0] cfg_len_a,
    input  logic [PHASE_W-1:0] cfg_len_b,
    input  logic [MODE_W-1:0]  cfg_mode,
    input  logic               kick,
    input  logic               tick,
    output logic               run,
    output logic               restart,
    output logic               set_a,
    output logic               set_b,
    output logic               rst_req,
    output logic [MODE_W-1:0]  rst_mode
);

    wdg_state_e state, state_n;
    logic [PHASE_W-1:0] phase_cnt;
    logic last_tick;

    assign run       = (state == ST_PHASE1) || (state == ST_PHASE2);
    assign restart   = kick && run;
    assign last_tick = tick && (phase_cnt == ((state == ST_PHASE1) ? cfg_len_a : cfg_len_b));

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (cfg_en) state_n = ST_PHASE1;
            ST_PHASE1: begin
                if (kick)           state_n = ST_PHASE1;
                else if (!cfg_en)   state_n = ST_IDLE;
                else if (last_tick) state_n = ST_PHASE2;
            end
            ST_PHASE2: begin
                if (kick)           state_n = ST_PHASE1;
                else if (last_tick) state_n = ST_FIRED;
            end
            ST_FIRED:  state_n = ST_FIRED;
        endcase
    end

    assign set_a = (state == ST_PHASE1) && (state_n == ST_PHASE2);
    assign set_b = (state == ST_PHASE2) && (state_n == ST_FIRED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_cnt <= '0;
            rst_req   <= 1'b0;
            rst_mode  <= MODE_AT_RESET;
        end else begin
            if (!run || restart || (state_n != state)) phase_cnt <= '0;
            else if (tick)                             phase_cnt <= phase_cnt + PHASE_W'(1);
            rst_req <= set_b;
            if (set_b) rst_mode <= cfg_mode;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R4
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> $stable(rst_mode)); // R4
    AST_LATCHED_PHASE2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PHASE2 && !cfg_en) |=> (state != ST_IDLE)); // R6
    AST_FIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRED) |=> (state == ST_FIRED && !rst_req)); // R10

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int BASE_EXP = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq,
    output logic               rst_req,
    output logic [1:0]         rst_mode
);

    logic               cfg_en;
    logic [SCALE_W-1:0] cfg_scale;
    logic [PHASE_W-1:0] cfg_len_a, cfg_len_b;
    logic [MODE_W-1:0]  cfg_mode;
    logic kick, flag_a, flag_b, set_a, set_b, run, restart, tick;

    wdg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .set_a, .set_b, .cfg_en, .cfg_scale, .cfg_len_a, .cfg_len_b,
        .cfg_mode, .kick, .flag_a, .flag_b
    );

    wdg_tick #(.BASE_EXP(BASE_EXP)) u_tick (
        .clk, .rst_n, .run, .restart, .scale(cfg_scale), .tick
    );

    wdg_fsm u_fsm (
        .clk, .rst_n, .cfg_en, .cfg_len_a, .cfg_len_b, .cfg_mode,
        .kick, .tick, .run, .restart, .set_a, .set_b, .rst_req, .rst_mode
    );

    assign irq = flag_a;

    AST_IRQ_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set_a)); // R11

endmodule

// File: tb/wdg_timer_tb.sv
module wdg_timer_tb;

    localparam int E = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;
    logic [1:0]  rst_mode;

    int cyc = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    // monitor
    bit mon_clr = 0;
    int irq_cyc = -1, rst_cyc = -1, rst_cnt = 0;
    logic [1:0] mode_seen = '0;

    wdg_timer #(.ADDR_W(4), .BASE_EXP(E)) u_dut (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .irq, .rst_req, .rst_mode
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mon_clr) begin
            irq_cyc = -1; rst_cyc = -1; rst_cnt = 0; mode_seen = '0;
        end else begin
            if (irq && irq_cyc < 0) irq_cyc = cyc;
            if (rst_req) begin rst_cnt++; rst_cyc = cyc; mode_seen = rst_mode; end
        end
    end

    function automatic int tlen(int s); return 1 << (E + s); endfunction
    function automatic int exp_irq(int c, int s, int a); return c + 1 + tlen(s) * (a + 1); endfunction
    function automatic int exp_rst(int c, int s, int a, int b); return c + 1 + tlen(s) * (a + b + 2); endfunction
    function automatic logic [31:0] ctrl_word(bit en, int s, int a, int b, int m);
        return (32'(en) << 31) | (32'(s) << 29) | (32'(a) << 22) | (32'(b) << 15) | 32'(m);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hw_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        mon_clr = 1; @(negedge clk); #1; mon_clr = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, output int c);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk); bus_we = 0; c = cyc;
    endtask

    task automatic wr_at(int t, logic [3:0] a, logic [31:0] d, output int c);
        while (cyc < t - 1) @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk); bus_we = 0; c = cyc;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_cyc(int t);
        while (cyc < t) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: all requirements, actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int c, c2, ck;
        logic [31:0] d;
        void'($urandom(32'h1234_5EED));
        hw_reset();

        // R1 reset state
        rd(4'h8, d); chk("R1 ctrl", d, 32'h1);
        rd(4'h4, d); chk("R1 status", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);
        rd(4'h0, d); chk("R1 kick reads zero", d, 0);

        // R2 readback masks unused bits
        wr(4'h8, 32'hFFFF_FFFF, c);
        rd(4'h8, d); chk("R2 all ones", d, 32'hE7CF8003);
        wr(4'h8, 32'h0, c);
        rd(4'h8, d); chk("R2 zero", d, 0);
        hw_reset();

        // R5 disable during phase one holds, re-enable restarts
        wr(4'h8, ctrl_word(1, 0, 3, 1, 2), c);
        wait_cyc(c + 8);
        wr(4'h8, ctrl_word(0, 0, 3, 1, 2), c2);
        wait_cyc(c2 + 60);
        chk("R5 no irq while disabled", irq_cyc, -1);
        chk("R5 no reset while disabled", rst_cnt, 0);
        rd(4'h4, d); chk("R5 status clean", d, 0);
        wr(4'h8, ctrl_word(1, 0, 3, 1, 2), c);
        wait_cyc(exp_rst(c, 0, 3, 1) + 2);
        chk("R5 irq from fresh start", irq_cyc, exp_irq(c, 0, 3));
        chk("R5 reset from fresh start", rst_cyc, exp_rst(c, 0, 3, 1));
        hw_reset();

        // R6 latched after phase one
        wr(4'h8, ctrl_word(1, 1, 1, 2, 0), c);
        wait_cyc(exp_irq(c, 1, 1));
        chk("R6 irq at expiry", irq_cyc, exp_irq(c, 1, 1));
        wr(4'h8, ctrl_word(0, 1, 1, 2, 0), c2);
        wait_cyc(exp_rst(c, 1, 1, 2) + 2);
        chk("R6 reset despite disable", rst_cyc, exp_rst(c, 1, 1, 2));
        chk("R6 mode", mode_seen, 0);
        hw_reset();

        // R7 kick word
        wr(4'h8, ctrl_word(1, 0, 3, 1, 1), c);
        wr(4'h0, 32'h7FFF_FFFF, c2);
        wait_cyc(exp_irq(c, 0, 3));
        chk("R7 bit31 clear ignored", irq_cyc, exp_irq(c, 0, 3));
        wr_at(c + 20, 4'h0, 32'h8000_0000, ck);
        wait_cyc(ck + 24 + 3);
        chk("R7 kick in phase two restarts", rst_cyc, ck + 24);
        chk("R7 one pulse", rst_cnt, 1);
        hw_reset();

        // R8 / R11 status clearing
        wr(4'h8, ctrl_word(1, 0, 1, 7, 2), c);
        wr_at(exp_irq(c, 0, 1), 4'h4, 32'h8000_0000, c2);
        rd(4'h4, d); chk("R8 set wins over clear", d, 32'h8000_0000);
        chk("R11 irq with flag", irq, 1);
        wr(4'h4, 32'h0, c2);
        rd(4'h4, d); chk("R8 zero write keeps flag", d, 32'h8000_0000);
        wr(4'h4, 32'h8000_0000, c2);
        rd(4'h4, d); chk("R8 clear", d, 0);
        chk("R11 irq drops", irq, 0);
        wait_cyc(exp_rst(c, 0, 1, 7) + 2);
        rd(4'h4, d); chk("R8 phase two flag", d, 32'h4000_0000);
        wr(4'h4, 32'h4000_0000, c2);
        rd(4'h4, d); chk("R8 clear phase two", d, 0);
        hw_reset();

        // R9 kick on expiry edge
        wr(4'h8, ctrl_word(1, 1, 2, 0, 1), c);
        wr_at(exp_irq(c, 1, 2), 4'h0, 32'h8000_0000, ck);
        rd(4'h4, d); chk("R9 no flag on kicked edge", d, 0);
        wait_cyc(ck + 8 * 4 + 2);
        chk("R9 irq shifted", irq_cyc, ck + 24);
        chk("R9 reset shifted", rst_cyc, ck + 32);

        // R10 idle after firing
        wr(4'h0, 32'h8000_0000, c2);
        wr(4'h8, ctrl_word(1, 0, 0, 0, 2), c2);
        wait_cyc(c2 + 200);
        chk("R10 no second pulse", rst_cnt, 1);
        chk("R10 rst_req low", rst_req, 0);

        // R3 / R4 directed corners then random
        for (int i = 0; i < 10; i++) begin
            int s, a, b, m;
            logic [31:0] w;
            if (i == 0) begin s = 0; a = 0; b = 0; m = 0; end
            else if (i == 1) begin s = 3; a = 31; b = 31; m = 2; end
            else begin s = $urandom % 4; a = $urandom % 32; b = $urandom % 32; m = $urandom % 3; end
            hw_reset();
            w = ctrl_word(1, s, a, b, m);
            wr(4'h8, w, c);
            wait_cyc(exp_rst(c, s, a, b) + 3);
            chk("R3 phase one expiry", irq_cyc, exp_irq(c, s, a));
            chk("R4 reset edge", rst_cyc, exp_rst(c, s, a, b));
            chk("R4 single pulse", rst_cnt, 1);
            chk("R4 mode code", mode_seen, m);
            rd(4'h4, d); chk("R4 both flags", d, 32'hC000_0000);
            rd(4'h8, d); chk("R2 random readback", d, w);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule